// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the serial test access port of a memory device. A test clock, a mode-select line and a serial data input steer a sixteen-state controller. The controller picks one of several scan paths between the serial input and the serial output. A three-bit instruction chooses the path. The paths are a single-bit pass-through stage, a fixed 32-bit identity word, and a boundary chain with one cell per device pin.

The boundary chain has three jobs. It captures a parallel snapshot of the pins. It shifts that snapshot out while new content shifts in. It then moves the new content into a held update stage, which can drive the pins. One instruction lets the update stage drive the pins. Another samples the pins while forcing the memory's data outputs to high impedance. A third samples the pins and preloads the chain without changing normal operation.

There is no separate test reset pin. The controller and the instruction register start from the asynchronous power-up reset. The controller also returns to the reset state when the mode-select line is held high. On the board, the mode-select and serial-input lines must be pulled up so that they read as 1 when left undriven.

Top module: `scan_tap_port`

## Requirements
- R1: While `rst_ni` is low and after it is released, the controller is in Test-Logic-Reset and the identity instruction (code 001) is active. `tdo_en_o`, `pin_drive_o` and `float_o` are all 0.
- R2: The controller follows the standard sixteen-state transitions on the rising edge of `tck_i`. Five rising edges with `tms_i` = 1 return it to Test-Logic-Reset from any state. Entering Test-Logic-Reset reloads the identity instruction.
- R3: The instruction register is 3 bits wide and shifts least significant bit first. Capture-IR loads the pattern 001, so the first bits shifted out are 1, 0, 0. A newly shifted code takes effect only at Update-IR.
- R4: The instruction codes are: 000 drives the pins from the boundary chain; 001 selects the identity word; 010 samples the pins with the outputs floated; 100 samples and preloads; 111 selects the pass-through stage.
- R5: With the pass-through stage selected, Capture-DR loads 0. The path from `tdi_i` to `tdo_o` is then a one-bit delay.
- R6: Codes 011, 101 and 110 behave exactly like the pass-through code 111.
- R7: The identity instruction captures the 32-bit word {3'b000 revision, 17'h00285 device code, 11'h033 vendor code, 1'b1}. It shifts out bit 0 first.
- R8: Under codes 000, 010 and 100, Capture-DR loads `pin_in_i[i]` into chain cell i. Cell 0 is nearest `tdo_o`, and all 107 cells shift out in order.
- R9: Under codes 000, 010 and 100, Update-DR copies the chain into `pin_out_o`. Under any other instruction, `pin_out_o` is left unchanged. `pin_drive_o` is 1 only while code 000 is active.
- R10: `float_o` is 1 only while code 010 is active. Code 100 leaves it at 0.
- R11: `tdo_o` and `tdo_en_o` change only on the falling edge of `tck_i`. `tdo_en_o` is 1 only during Shift-IR and Shift-DR. `tdo_o` is 0 whenever `tdo_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| tms_i | input | 1 | Mode select, sampled on rising edge |
| tdi_i | input | 1 | Serial data in, sampled on rising edge |
| tdo_o | output | 1 | Serial data out, updated on falling edge |
| tdo_en_o | output | 1 | Serial output enable |
| pin_in_i | input | 107 | Parallel sample of device pins |
| pin_out_o | output | 107 | Boundary update stage contents |
| pin_drive_o | output | 1 | Update stage owns the pins |
| float_o | output | 1 | Force memory data outputs to high impedance |

## Verification
Under the float-and-sample instruction, two things hold in the same test-clock cycle: the output-float control is high, and the boundary capture takes in the pins. The bench changes `pin_in_i` one half-cycle before the Capture-DR edge while `float_o` is high. It then checks that the shifted-out chain holds exactly the new pattern and that `pin_drive_o` stays low.

A second overlap occurs at Update-IR. There, `pin_drive_o` rises on the same edge as the instruction changes. The bench checks that `pin_out_o` already shows the pattern preloaded under sample/preload at that moment.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int unsigned IR_W = 3;
  localparam logic [IR_W-1:0] OP_DRIVE  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_FLOAT  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_PASS   = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef enum logic [1:0] {PATH_PASS, PATH_IDENT, PATH_CHAIN} dr_path_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e nxt;

  always_comb begin
    unique case (state_o)
      ST_TLR:    nxt = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms_i ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms_i ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms_i ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_TLR;
    else         state_o <= nxt;
  end

  a_r2_reset_sticks: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_o == ST_TLR && tms_i) |=> state_o == ST_TLR);
  a_r2_capture_to_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_o == ST_CAP_DR && !tms_i) |=> state_o == ST_SHF_DR);
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tdi_i,
  input  tap_state_e      state_i,
  output logic [IR_W-1:0] ir_o,
  output logic            sr_lsb_o
);
  logic [IR_W-1:0] sr;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr   <= '0;
      ir_o <= OP_IDENT;
    end else begin
      unique case (state_i)
        ST_TLR:    ir_o <= OP_IDENT;
        ST_CAP_IR: sr   <= IR_CAPTURE_PAT;
        ST_SHF_IR: sr   <= {tdi_i, sr[IR_W-1:1]};
        ST_UPD_IR: ir_o <= sr;
        default:   ;
      endcase
    end
  end

  assign sr_lsb_o = sr[0];

  a_r3_capture_pattern: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_CAP_IR |=> sr == IR_CAPTURE_PAT);
  a_r2_reset_loads_ident: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_TLR |=> ir_o == OP_IDENT);
  a_r3_ir_holds: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UPD_IR && state_i != ST_TLR) |=> $stable(ir_o));
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int unsigned CHAIN_W = 107,
  parameter int unsigned ID_W    = 32,
  parameter logic [ID_W-1:0] ID_VAL = '1
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tdi_i,
  input  tap_state_e         state_i,
  input  dr_path_e           path_i,
  input  logic [CHAIN_W-1:0] pin_i,
  output logic [CHAIN_W-1:0] upd_o,
  output logic               lsb_o
);
  logic               pass_q;
  logic [ID_W-1:0]    id_sr;
  logic [CHAIN_W-1:0] chain_sr;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q   <= 1'b0;
      id_sr    <= '0;
      chain_sr <= '0;
      upd_o    <= '0;
    end else begin
      unique case (state_i)
        ST_CAP_DR: begin
          unique case (path_i)
            PATH_IDENT: id_sr    <= ID_VAL;
            PATH_CHAIN: chain_sr <= pin_i;
            default:    pass_q   <= 1'b0;
          endcase
        end
        ST_SHF_DR: begin
          unique case (path_i)
            PATH_IDENT: id_sr    <= {tdi_i, id_sr[ID_W-1:1]};
            PATH_CHAIN: chain_sr <= {tdi_i, chain_sr[CHAIN_W-1:1]};
            default:    pass_q   <= tdi_i;
          endcase
        end
        ST_UPD_DR: if (path_i == PATH_CHAIN) upd_o <= chain_sr;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (path_i)
      PATH_IDENT: lsb_o = id_sr[0];
      PATH_CHAIN: lsb_o = chain_sr[0];
      default:    lsb_o = pass_q;
    endcase
  end

  a_r5_pass_captures_zero: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_DR && path_i == PATH_PASS) |=> !pass_q);
  a_r9_update_only_on_upd: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i != ST_UPD_DR |=> $stable(upd_o));
  a_r8_chain_captures_pins: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_DR && path_i == PATH_CHAIN) |=> chain_sr == $past(pin_i));
endmodule

// File: rtl/scan_tap_port.sv
module scan_tap_port
  import scan_tap_pkg::*;
#(
  parameter int unsigned CHAIN_W  = 107,
  parameter logic [2:0]  REV      = 3'h0,
  parameter logic [16:0] DEV_CODE = 17'h00285,
  parameter logic [10:0] VENDOR   = 11'h033
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic               tdo_en_o,
  input  logic [CHAIN_W-1:0] pin_in_i,
  output logic [CHAIN_W-1:0] pin_out_o,
  output logic               pin_drive_o,
  output logic               float_o
);
  localparam int unsigned ID_W = 32;
  localparam logic [ID_W-1:0] ID_VAL = {REV, DEV_CODE, VENDOR, 1'b1};

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_lsb, dr_lsb;
  dr_path_e        path;

  tap_fsm u_fsm (.tck_i, .rst_ni, .tms_i, .state_o(state));

  tap_ir u_ir (.tck_i, .rst_ni, .tdi_i, .state_i(state), .ir_o(ir), .sr_lsb_o(ir_lsb));

  always_comb begin
    unique case (ir)
      OP_IDENT:                    path = PATH_IDENT;
      OP_DRIVE, OP_FLOAT, OP_SAMPLE: path = PATH_CHAIN;
      default:                     path = PATH_PASS;  // reserved codes alias pass-through
    endcase
  end

  tap_dr #(.CHAIN_W(CHAIN_W), .ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
    .tck_i, .rst_ni, .tdi_i, .state_i(state), .path_i(path),
    .pin_i(pin_in_i), .upd_o(pin_out_o), .lsb_o(dr_lsb)
  );

  assign pin_drive_o = (ir == OP_DRIVE);
  assign float_o     = (ir == OP_FLOAT);

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end else begin
      tdo_en_o <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
      tdo_o    <= (state == ST_SHF_IR) ? ir_lsb :
                  (state == ST_SHF_DR) ? dr_lsb : 1'b0;
    end
  end

  a_r11_enable_in_shift: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == (state == ST_SHF_IR || state == ST_SHF_DR));
  a_r11_quiet_when_off: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_en_o |-> !tdo_o);
  a_r10_float_excludes_drive: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(float_o && pin_drive_o));
endmodule

// File: tb/tb_scan_tap_port.sv
module tb_scan_tap_port;
  localparam int W = 107;
  logic tck = 1'b0, rst_ni = 1'b0, tms_i = 1'b1, tdi_i = 1'b1;
  logic tdo_o, tdo_en_o, pin_drive_o, float_o;
  logic [W-1:0] pin_in_i = '0, pin_out_o;
  int checks = 0, fails = 0;

  always #2 tck = ~tck;

  scan_tap_port dut (.tck_i(tck), .rst_ni, .tms_i, .tdi_i, .tdo_o, .tdo_en_o,
    .pin_in_i, .pin_out_o, .pin_drive_o, .float_o);

  function automatic logic [31:0] exp_id();
    return {3'h0, 17'h00285, 11'h033, 1'b1};
  endfunction

  function automatic logic [127:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms_i = m; tdi_i = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic to_idle();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1);
    tick(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo_o;
      tick(i == 2, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input logic [127:0] din, input int n, output logic [127:0] dout, output logic en);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    en = tdo_en_o;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo_o;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  logic [127:0] dout, din, pat, pre;
  logic [2:0] cap;
  logic en;

  initial begin
    void'($urandom(32'd1149));
    #7;
    chk(tdo_en_o == 0 && pin_drive_o == 0 && float_o == 0, "R1 reset outputs",
        {tdo_en_o, pin_drive_o, float_o}, 0);
    @(negedge tck); rst_ni = 1'b1; #1;
    tick(0, 0);
    chk(tdo_en_o == 0, "R11 idle enable", tdo_en_o, 0);
    scan_dr('0, 32, dout, en);
    chk(dout[31:0] == exp_id(), "R1 R7 identity after reset", dout, exp_id());
    chk(en == 1, "R11 enable in shift", en, 1);
    chk(tdo_en_o == 0 && tdo_o == 0, "R11 quiet after shift", {tdo_en_o, tdo_o}, 0);

    load_ir(3'b111, cap);
    chk(cap == 3'b001, "R3 capture pattern", cap, 3'b001);
    din = 128'hA5;
    scan_dr(din, 8, dout, en);
    chk(dout[7:0] == {din[6:0], 1'b0}, "R5 pass-through delay", dout[7:0], {din[6:0], 1'b0});

    // R11: falling-edge launch, checked mid-shift in pass-through
    tick(1, 0); tick(0, 0); tick(0, 0);
    tms_i = 0; tdi_i = 1; @(posedge tck); #1;
    chk(tdo_o == 0, "R11 no change at rise", tdo_o, 0);
    @(negedge tck); #1;
    chk(tdo_o == 1, "R11 change at fall", tdo_o, 1);
    tick(1, 0); tick(1, 0); tick(0, 0);

    foreach (cap[k]) begin end
    for (int c = 0; c < 3; c++) begin
      logic [2:0] code;
      code = (c == 0) ? 3'b011 : (c == 1) ? 3'b101 : 3'b110;
      load_ir(code, cap);
      din = rnd_vec();
      scan_dr(din, 10, dout, en);
      chk(dout[9:0] == {din[8:0], 1'b0}, "R6 reserved acts as pass", dout[9:0], {din[8:0], 1'b0});
      chk(pin_drive_o == 0 && float_o == 0, "R4 R6 reserved no pin effect", {pin_drive_o, float_o}, 0);
    end

    // R2: escape from Shift-DR with five TMS highs
    load_ir(3'b111, cap);
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
    to_idle();
    scan_dr('0, 32, dout, en);
    chk(dout[31:0] == exp_id(), "R2 five-high escape reloads identity", dout[31:0], exp_id());

    // R8 R9 R10: sample/preload with random patterns
    for (int it = 0; it < 4; it++) begin
      load_ir(3'b100, cap);
      chk(pin_drive_o == 0 && float_o == 0, "R10 sample keeps outputs", {pin_drive_o, float_o}, 0);
      pat = rnd_vec(); pin_in_i = pat[W-1:0];
      pre = rnd_vec();
      scan_dr(pre, W, dout, en);
      chk(dout[W-1:0] == pat[W-1:0], "R8 sample capture", dout[W-1:0], pat[W-1:0]);
      chk(pin_out_o == pre[W-1:0], "R9 preload update", pin_out_o, pre[W-1:0]);
    end

    // R9: drive instruction exposes preload on the IR update edge
    load_ir(3'b000, cap);
    chk(pin_drive_o == 1 && pin_out_o == pre[W-1:0], "R9 drive shows preload",
        {pin_drive_o, pin_out_o}, {1'b1, pre[W-1:0]});
    pat = rnd_vec(); pin_in_i = pat[W-1:0];
    din = rnd_vec();
    scan_dr(din, W, dout, en);
    chk(dout[W-1:0] == pat[W-1:0], "R8 drive-mode capture", dout[W-1:0], pat[W-1:0]);
    chk(pin_out_o == din[W-1:0], "R9 drive-mode update", pin_out_o, din[W-1:0]);

    // R9: identity update leaves pin_out untouched
    load_ir(3'b001, cap);
    chk(pin_drive_o == 0, "R9 drive off", pin_drive_o, 0);
    scan_dr(rnd_vec(), 32, dout, en);
    chk(pin_out_o == din[W-1:0], "R9 identity ignores update", pin_out_o, din[W-1:0]);

    // R10: float-and-sample, pins change half a cycle before capture
    load_ir(3'b010, cap);
    chk(float_o == 1 && pin_drive_o == 0, "R10 float asserted", {float_o, pin_drive_o}, 2'b10);
    tick(1, 0);
    pat = rnd_vec(); pin_in_i = pat[W-1:0];
    tick(0, 0);
    tick(0, 0);
    dout = '0;
    for (int i = 0; i < W; i++) begin
      dout[i] = tdo_o;
      tick(i == W - 1, 1'b0);
    end
    tick(1, 0); tick(0, 0);
    chk(dout[W-1:0] == pat[W-1:0], "R8 R10 capture while floated", dout[W-1:0], pat[W-1:0]);
    chk(pin_out_o == '0, "R9 float-mode update", pin_out_o, '0);

    // R3: code takes effect only at Update-IR (pause before update)
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 1); tick(0, 1); tick(1, 1);
    tick(0, 0);
    chk(float_o == 1 && pin_drive_o == 0, "R3 no change before update", {float_o, pin_drive_o}, 2'b10);
    tick(1, 0); tick(1, 0); tick(0, 0);
    scan_dr(128'h1, 4, dout, en);
    chk(float_o == 0 && dout[0] == 0, "R4 pass selected after update", {float_o, dout[0]}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule